// File: doc/BRIEF.md
# Latched Fault Flag Encoder

This block collects fault indications from a dual-channel isolated gate driver and reduces them to two latched flag outputs that a host microcontroller reads at its own pace. Three conditions from the primary side arrive as levels: supply under-voltage, supply over-voltage and over-temperature. Each gate channel also reports three secondary-side event kinds as single-cycle pulses: an under-voltage echo, an over-voltage echo and an over-current. The same block drives a PWM-inhibit line for both gate channels whenever a primary-side condition is present.

The two fault classes clear in different ways. A primary flag runs through the states PF_CLEAR, PF_ACTIVE and PF_HELD. PF_CLEAR goes to PF_ACTIVE when the condition is seen. PF_ACTIVE goes to PF_HELD when the condition goes away. PF_HELD goes back to PF_ACTIVE if the condition returns, and to PF_CLEAR on an accepted host clear. A host clear has no effect in PF_ACTIVE. A secondary flag has two states. SF_IDLE goes to SF_SET on any event of its kind from either channel. SF_SET goes back to SF_IDLE on an accepted host clear, unless an event arrives in the same cycle. Restart forces every flag to its clear state.

The host clear input goes through a width qualifier with the states RQ_IDLE, RQ_MEASURE and RQ_ARMED. A high sample in RQ_IDLE moves to RQ_MEASURE. In RQ_MEASURE the qualifier counts high samples and moves to RQ_ARMED when the count reaches the minimum width. A low sample in RQ_MEASURE returns to RQ_IDLE without clearing anything. A low sample in RQ_ARMED returns to RQ_IDLE and emits a one-cycle clear strobe. The clear therefore takes effect on the falling edge of a pulse that was wide enough.

Top module: `fault_flag_latch`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, fault1_o, fault2_o and pwm_inhibit_o are 0.
- R2: A primary condition sampled high at a clock edge (with restart low) appears on {fault1_o,fault2_o} after that edge. The codes are: under-voltage 2'b10, over-voltage 2'b01, over-temperature 2'b11.
- R3: A secondary under-voltage event pulse on either channel sets fault1_o. A secondary over-voltage or over-current event pulse on either channel sets fault2_o. In both cases the flag is set after the edge that samples the pulse.
- R4: An accepted flag-reset has no effect on a primary flag whose condition is still high.
- R5: A primary flag stays set after its condition drops, and it is cleared only by an accepted flag-reset.
- R6: An accepted flag-reset clears the secondary flags. The next event of the same kind sets its flag again.
- R7: While restart_i is high, every flag reads 0 from the next edge on. A primary condition that is still present sets its flag again once restart_i is low.
- R8: pwm_inhibit_o is high exactly when some primary condition was high, with restart low, at the previous edge. Secondary events never raise it.
- R9: flag_clr_i is accepted only when it is high for at least RST_MIN_CYCLES consecutive edges. An accepted pulse clears the flags at the second edge after the first low sample. A pulse one edge shorter has no effect.
- R10: A secondary event sampled at the same edge as the clear action leaves its flag set.
- R11: When several sources are active at once, {fault1_o,fault2_o} is the bitwise OR of their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Global restart level; clears all flags |
| prim_uv_i | input | 1 | Primary supply under-voltage level |
| prim_ov_i | input | 1 | Primary supply over-voltage level |
| prim_ot_i | input | 1 | Over-temperature level |
| sec_uv_evt_i | input | N_CH | Per-channel secondary under-voltage event pulses |
| sec_ov_evt_i | input | N_CH | Per-channel secondary over-voltage event pulses |
| sec_oc_evt_i | input | N_CH | Per-channel over-current event pulses |
| flag_clr_i | input | 1 | Host flag-reset pulse |
| fault1_o | output | 1 | Latched fault flag, high bit of the code |
| fault2_o | output | 1 | Latched fault flag, low bit of the code |
| pwm_inhibit_o | output | 1 | Inhibits PWM on both gate channels |

## Verification
The embedded properties check several rules on every cycle. A primary flag is set whenever its condition was present, and restart clears everything in the next cycle. A secondary event always sets its flag, even when a clear arrives with it. The clear strobe lasts a single cycle and only follows a low sample, and inhibit only occurs alongside a raised flag. Some behaviour needs multi-step histories that only the bench scenarios build up. These cover the exact width boundary of the flag-reset qualifier, the latch that persists after a primary condition ends, and the code produced for every combination of primary sources. They also cover the way flags return after restart is released.

// File: rtl/fault_flag_pkg.sv
package fault_flag_pkg;

    typedef enum logic [1:0] {
        PF_CLEAR  = 2'd0,
        PF_ACTIVE = 2'd1,
        PF_HELD   = 2'd2
    } prim_state_t;

    typedef enum logic {
        SF_IDLE = 1'b0,
        SF_SET  = 1'b1
    } sec_state_t;

    typedef enum logic [1:0] {
        RQ_IDLE    = 2'd0,
        RQ_MEASURE = 2'd1,
        RQ_ARMED   = 2'd2
    } qual_state_t;

    localparam int unsigned NUM_PRIM = 3;
    localparam int unsigned NUM_SEC  = 3;

    // {fault1, fault2} code contributed by each source
    function automatic logic [1:0] prim_code(input int unsigned idx);
        unique case (idx)
            0:       return 2'b10;
            1:       return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] sec_code(input int unsigned idx);
        return (idx == 0) ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/clr_width_qual.sv
module clr_width_qual
    import fault_flag_pkg::*;
#(
    parameter int unsigned RST_MIN_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_clr_i,
    output logic clr_fire_o
);
    localparam int unsigned CNT_W = $clog2(RST_MIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_MIN_CYCLES - 1);
    localparam bit SINGLE = (RST_MIN_CYCLES <= 1);

    qual_state_t       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              fire_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RQ_IDLE;
            cnt_q      <= '0;
            clr_fire_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            clr_fire_o <= fire_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire_d  = 1'b0;
        unique case (state_q)
            RQ_IDLE: begin
                if (flag_clr_i) begin
                    cnt_d   = CNT_W'(1);
                    state_d = SINGLE ? RQ_ARMED : RQ_MEASURE;
                end
            end
            RQ_MEASURE: begin
                if (!flag_clr_i) begin
                    state_d = RQ_IDLE;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = RQ_ARMED;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            RQ_ARMED: begin
                if (!flag_clr_i) begin
                    state_d = RQ_IDLE;
                    fire_d  = 1'b1;
                end
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    // R9
    fire_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire_o |-> !$past(flag_clr_i));

    // R9
    fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire_o |=> !clr_fire_o);

endmodule

// File: rtl/prim_flag_cell.sv
module prim_flag_cell
    import fault_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic cond_i,
    input  logic clr_fire_i,
    output logic flag_o,
    output logic active_o
);
    prim_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PF_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = PF_CLEAR;
        end else begin
            unique case (state_q)
                PF_CLEAR:  if (cond_i) state_d = PF_ACTIVE;
                PF_ACTIVE: if (!cond_i) state_d = PF_HELD;
                PF_HELD: begin
                    if (cond_i)          state_d = PF_ACTIVE;
                    else if (clr_fire_i) state_d = PF_CLEAR;
                end
                default: state_d = PF_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag_o   = (state_q != PF_CLEAR);
        active_o = (state_q == PF_ACTIVE);
    end

    // R4
    prim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i && !restart_i) |=> flag_o);

    // R7
    prim_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !flag_o);

endmodule

// File: rtl/sec_flag_cell.sv
module sec_flag_cell
    import fault_flag_pkg::*;
#(
    parameter int unsigned N_CH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic [N_CH-1:0] evt_i,
    input  logic            clr_fire_i,
    output logic            flag_o
);
    sec_state_t state_q, state_d;
    logic       any_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        any_evt = |evt_i;
        state_d = state_q;
        if (restart_i) begin
            state_d = SF_IDLE;
        end else begin
            unique case (state_q)
                SF_IDLE: if (any_evt) state_d = SF_SET;
                SF_SET:  if (clr_fire_i && !any_evt) state_d = SF_IDLE;
                default: state_d = SF_IDLE;
            endcase
        end
    end

    always_comb flag_o = (state_q == SF_SET);

    // R10
    sec_evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_evt && !restart_i) |=> flag_o);

    // R6
    sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fire_i && !any_evt) |=> !flag_o);

endmodule

// File: rtl/fault_flag_latch.sv
module fault_flag_latch
    import fault_flag_pkg::*;
#(
    parameter int unsigned N_CH           = 2,
    parameter int unsigned RST_MIN_CYCLES = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart_i,
    input  logic            prim_uv_i,
    input  logic            prim_ov_i,
    input  logic            prim_ot_i,
    input  logic [N_CH-1:0] sec_uv_evt_i,
    input  logic [N_CH-1:0] sec_ov_evt_i,
    input  logic [N_CH-1:0] sec_oc_evt_i,
    input  logic            flag_clr_i,
    output logic            fault1_o,
    output logic            fault2_o,
    output logic            pwm_inhibit_o
);
    logic                  clr_fire;
    logic [NUM_PRIM-1:0]   prim_cond, prim_flag, prim_active;
    logic [NUM_SEC-1:0]    sec_flag;
    logic [N_CH-1:0]       sec_evt [NUM_SEC];
    logic [1:0]            code;

    assign prim_cond  = {prim_ot_i, prim_ov_i, prim_uv_i};
    assign sec_evt[0] = sec_uv_evt_i;
    assign sec_evt[1] = sec_ov_evt_i;
    assign sec_evt[2] = sec_oc_evt_i;

    clr_width_qual #(.RST_MIN_CYCLES(RST_MIN_CYCLES)) qual_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_clr_i (flag_clr_i),
        .clr_fire_o (clr_fire)
    );

    for (genvar p = 0; p < NUM_PRIM; p++) begin : g_prim
        prim_flag_cell prim_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .restart_i  (restart_i),
            .cond_i     (prim_cond[p]),
            .clr_fire_i (clr_fire),
            .flag_o     (prim_flag[p]),
            .active_o   (prim_active[p])
        );
    end

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        sec_flag_cell #(.N_CH(N_CH)) sec_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .restart_i  (restart_i),
            .evt_i      (sec_evt[s]),
            .clr_fire_i (clr_fire),
            .flag_o     (sec_flag[s])
        );
    end

    always_comb begin
        code = 2'b00;
        for (int p = 0; p < NUM_PRIM; p++)
            if (prim_flag[p]) code = code | prim_code(p);
        for (int s = 0; s < NUM_SEC; s++)
            if (sec_flag[s]) code = code | sec_code(s);
        fault1_o      = code[1];
        fault2_o      = code[0];
        pwm_inhibit_o = |prim_active;
    end

    // R8
    inhibit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_inhibit_o |-> (fault1_o || fault2_o));

    // R8
    inhibit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prim_uv_i || prim_ov_i || prim_ot_i) && !restart_i) |=> pwm_inhibit_o);

endmodule

// File: tb/fault_flag_latch_tb_top.sv
module fault_flag_latch_tb_top;
    localparam int unsigned N_CH = 2;
    localparam int unsigned MINW = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0, p_uv = 1'b0, p_ov = 1'b0, p_ot = 1'b0, fclr = 1'b0;
    logic [N_CH-1:0] s_uv = '0, s_ov = '0, s_oc = '0;
    logic f1, f2, inh;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4ns clk = ~clk;

    fault_flag_latch #(.N_CH(N_CH), .RST_MIN_CYCLES(MINW)) dut_i (
        .clk(clk), .rst_n(rst_n), .restart_i(restart),
        .prim_uv_i(p_uv), .prim_ov_i(p_ov), .prim_ot_i(p_ot),
        .sec_uv_evt_i(s_uv), .sec_ov_evt_i(s_ov), .sec_oc_evt_i(s_oc),
        .flag_clr_i(fclr), .fault1_o(f1), .fault2_o(f2), .pwm_inhibit_o(inh)
    );

    // {uv, ov, ot, expected fault1, expected fault2}
    localparam logic [4:0] VEC [8] = '{
        5'b000_00, 5'b100_10, 5'b010_01, 5'b001_11,
        5'b110_11, 5'b101_11, 5'b011_11, 5'b111_11
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {f1,f2,inh} got %b expected %b", req, got, exp);
        end
    endtask

    task automatic clr_pulse(input int w);
        fclr = 1'b1;
        step(w);
        fclr = 1'b0;
        step(2);
    endtask

    task automatic do_restart();
        restart = 1'b1;
        step(1);
        restart = 1'b0;
        step(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        // R1: reset state
        chk("R1", {f1, f2, inh}, 3'b000);
        rst_n = 1'b1;
        step(1);
        chk("R1", {f1, f2, inh}, 3'b000);

        // R2 R11 R8 R5 R7: primary codes from the table
        for (int i = 0; i < 8; i++) begin
            {p_uv, p_ov, p_ot} = VEC[i][4:2];
            step(1);
            chk("R2_R11_R8", {f1, f2, inh}, {VEC[i][1:0], |VEC[i][4:2]});
            {p_uv, p_ov, p_ot} = 3'b000;
            step(1);
            chk("R5_R8", {f1, f2, inh}, {VEC[i][1:0], 1'b0});
            do_restart();
            chk("R7", {f1, f2, inh}, 3'b000);
        end

        // R4: clear ignored while condition present
        p_uv = 1'b1;
        step(1);
        clr_pulse(MINW);
        chk("R4", {f1, f2, inh}, 3'b101);
        p_uv = 1'b0;
        step(1);
        chk("R5", {f1, f2, inh}, 3'b100);
        // R9: one edge too short
        clr_pulse(MINW - 1);
        chk("R9", {f1, f2, inh}, 3'b100);
        clr_pulse(MINW);
        chk("R9_R5", {f1, f2, inh}, 3'b000);

        // R3 R6: secondary events
        s_uv = 2'b10;
        step(1);
        s_uv = '0;
        chk("R3", {f1, f2, inh}, 3'b100);
        s_oc = 2'b01;
        step(1);
        s_oc = '0;
        chk("R3_R11", {f1, f2, inh}, 3'b110);
        clr_pulse(MINW);
        chk("R6", {f1, f2, inh}, 3'b000);
        s_ov = 2'b01;
        step(1);
        s_ov = '0;
        chk("R6_R3", {f1, f2, inh}, 3'b010);
        clr_pulse(MINW);
        chk("R6", {f1, f2, inh}, 3'b000);

        // R10: event at the same edge as the clear action
        s_ov = 2'b10;
        step(1);
        s_ov = '0;
        fclr = 1'b1;
        step(MINW);
        fclr = 1'b0;
        step(1);
        s_uv = 2'b01;
        step(1);
        s_uv = '0;
        chk("R10", {f1, f2, inh}, 3'b100);
        clr_pulse(MINW);
        chk("R6", {f1, f2, inh}, 3'b000);

        // R7: restart with a persisting primary condition
        p_ov = 1'b1;
        step(1);
        restart = 1'b1;
        step(2);
        chk("R7", {f1, f2, inh}, 3'b000);
        restart = 1'b0;
        step(1);
        chk("R7", {f1, f2, inh}, 3'b011);
        p_ov = 1'b0;
        step(1);
        do_restart();
        chk("R7", {f1, f2, inh}, 3'b000);

        finish_run();
    end
endmodule